// File: doc/BRIEF.md
# Clock Phase Step Controller

This block sits between a 16-bit command register and a clock manager that supports dynamic phase shifting. Each write carries one command word. The block turns fine-step commands into single-cycle step requests with a direction. It waits for the clock manager's completion handshake before it accepts more work, and it keeps count of the signed fine offset that has built up. It also keeps a two-bit quarter-period index for one clock.

For instances that serve a receive channel, the block also holds a small count for the alignment between the line-valid strobe and the pixel data. A fine reset command brings the clock back to its nominal phase. It does this by issuing as many opposite-direction step requests as the counter holds, one request per completion. Writing the fine-reset code once after power-up is part of bringing the clock path up.

Top module: `phase_step_ctrl`

## Requirements
- R1: After reset, fineOffset, quarterIdx and dataShift are 0, and psEn, busy and overflow are low.
- R2: In the idle state, a write of 0x0001 raises psEn for exactly one cycle, starting the cycle after the write, with psInc=1. A write of 0x0002 does the same with psInc=0. busy stays high until psDone is sampled, and fineOffset moves by +1 or -1 in the cycle after psDone is sampled. fineOffset does not change while psDone is low.
- R3: fineOffset is a signed count limited to the range -255..+255. A step command that would take it past the limit issues no pulse and changes nothing.
- R4: A write of 0x0003 with a non-zero fineOffset issues |fineOffset| pulses in the direction opposite to its sign. Each pulse after the first follows the cycle after the previous psDone, and the sequence ends with fineOffset at 0. With fineOffset at 0, the write does nothing.
- R5: A write of 0x0004 increments quarterIdx modulo 4, a write of 0x0008 decrements it modulo 4, and a write of 0x000C clears it. Each result is visible in the cycle after the write, and none of these writes issues a pulse.
- R6: On receive instances (HAS_DATA_SHIFT=1), a write of 0x0010 raises dataShift, saturating at 3. A write of 0x0020 lowers it, saturating at 0. A write of 0x0030 clears it. With HAS_DATA_SHIFT=0, dataShift stays 0.
- R7: A write while busy is ignored and sets overflow. overflow stays set until reset.
- R8: Any other 16-bit word, including a known code with other bits set, changes nothing and issues no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Command write strobe |
| wrData | input | 16 | Command word |
| psDone | input | 1 | Completion handshake from the clock manager |
| psEn | output | 1 | One-cycle phase step request |
| psInc | output | 1 | Step direction, 1 = positive |
| busy | output | 1 | A step is outstanding |
| overflow | output | 1 | Sticky flag for a command dropped while busy |
| fineOffset | output | 9 | Signed accumulated fine offset |
| quarterIdx | output | 2 | Quarter-period index |
| dataShift | output | 2 | Line-valid to data shift count |

## Verification
Each result is due on a fixed cycle. A step pulse is due one cycle after the write edge. A quarter or shift change is due one cycle after the write. A fine offset change is due one cycle after the edge that samples psDone, and any further unwind pulse becomes visible in that same cycle. The bench drives every input on falling edges and samples one falling edge after each of these registering edges. A reference model in the bench, updated per command, supplies the expected offset, index, count and overflow. The bench also holds psDone back for a random one to three cycles, so that fineOffset is seen to stay put while psDone is low.

// File: rtl/phstep_pkg.sv
package phstep_pkg;
  localparam logic [15:0] CMD_FINE_UP  = 16'h0001;
  localparam logic [15:0] CMD_FINE_DN  = 16'h0002;
  localparam logic [15:0] CMD_FINE_CLR = 16'h0003;
  localparam logic [15:0] CMD_QTR_UP   = 16'h0004;
  localparam logic [15:0] CMD_QTR_DN   = 16'h0008;
  localparam logic [15:0] CMD_QTR_CLR  = 16'h000C;
  localparam logic [15:0] CMD_SH_UP    = 16'h0010;
  localparam logic [15:0] CMD_SH_DN    = 16'h0020;
  localparam logic [15:0] CMD_SH_CLR   = 16'h0030;

  typedef struct packed {
    logic fineUp;
    logic fineDn;
    logic qUp;
    logic qDn;
    logic qClr;
    logic sUp;
    logic sDn;
    logic sClr;
  } phStrobes_t;

  typedef enum logic { ST_IDLE, ST_WAIT } phState_t;
endpackage

// File: rtl/phstep_ctrl.sv
module phstep_ctrl
  import phstep_pkg::*;
#(
  parameter int FINE_MAX = 255,
  parameter int FINE_W   = 9,
  parameter int CMD_W    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [CMD_W-1:0]         wrData,
  input  logic                     psDone,
  input  logic signed [FINE_W-1:0] fineNow,
  output phStrobes_t               strobes,
  output logic                     psEn,
  output logic                     psInc,
  output logic                     busy,
  output logic                     overflow
);
  localparam logic signed [FINE_W-1:0] FINE_HI = FINE_W'(FINE_MAX);
  localparam logic signed [FINE_W-1:0] FINE_LO = -FINE_W'(FINE_MAX);
  localparam logic signed [FINE_W-1:0] ONE     = FINE_W'(1);

  phState_t state;
  logic     unwind;
  logic     lastStep;
  logic     acceptCmd;

  assign acceptCmd = (state == ST_IDLE) && wrEn;
  assign lastStep  = psInc ? (fineNow == -ONE) : (fineNow == ONE);
  assign busy      = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      psEn     <= 1'b0;
      psInc    <= 1'b0;
      unwind   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      psEn <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wrEn) begin
            if (wrData == CMD_W'(CMD_FINE_UP) && fineNow < FINE_HI) begin
              psEn <= 1'b1; psInc <= 1'b1; unwind <= 1'b0; state <= ST_WAIT;
            end else if (wrData == CMD_W'(CMD_FINE_DN) && fineNow > FINE_LO) begin
              psEn <= 1'b1; psInc <= 1'b0; unwind <= 1'b0; state <= ST_WAIT;
            end else if (wrData == CMD_W'(CMD_FINE_CLR) && fineNow != '0) begin
              psEn <= 1'b1; psInc <= fineNow[FINE_W-1]; unwind <= 1'b1; state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (wrEn) overflow <= 1'b1;
          if (psDone) begin
            if (unwind && !lastStep) psEn <= 1'b1;
            else state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.fineUp = busy && psDone && psInc;
    strobes.fineDn = busy && psDone && !psInc;
    strobes.qUp    = acceptCmd && wrData == CMD_W'(CMD_QTR_UP);
    strobes.qDn    = acceptCmd && wrData == CMD_W'(CMD_QTR_DN);
    strobes.qClr   = acceptCmd && wrData == CMD_W'(CMD_QTR_CLR);
    strobes.sUp    = acceptCmd && wrData == CMD_W'(CMD_SH_UP);
    strobes.sDn    = acceptCmd && wrData == CMD_W'(CMD_SH_DN);
    strobes.sClr   = acceptCmd && wrData == CMD_W'(CMD_SH_CLR);
  end
endmodule

// File: rtl/phstep_dp.sv
module phstep_dp
  import phstep_pkg::*;
#(
  parameter int FINE_W         = 9,
  parameter int QTR_W          = 2,
  parameter int SHIFT_W        = 2,
  parameter bit HAS_DATA_SHIFT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  phStrobes_t               strobes,
  output logic signed [FINE_W-1:0] fineOffset,
  output logic [QTR_W-1:0]         quarterIdx,
  output logic [SHIFT_W-1:0]       dataShift
);
  localparam logic [SHIFT_W-1:0] SHIFT_TOP = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fineOffset <= '0;
      quarterIdx <= '0;
    end else begin
      if (strobes.fineUp)      fineOffset <= fineOffset + 1'b1;
      else if (strobes.fineDn) fineOffset <= fineOffset - 1'b1;
      if (strobes.qClr)        quarterIdx <= '0;
      else if (strobes.qUp)    quarterIdx <= quarterIdx + 1'b1;
      else if (strobes.qDn)    quarterIdx <= quarterIdx - 1'b1;
    end
  end

  generate
    if (HAS_DATA_SHIFT) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rstN) dataShift <= '0;
        else if (strobes.sClr) dataShift <= '0;
        else if (strobes.sUp && dataShift != SHIFT_TOP) dataShift <= dataShift + 1'b1;
        else if (strobes.sDn && dataShift != '0) dataShift <= dataShift - 1'b1;
      end
    end else begin : g_noshift
      assign dataShift = '0;
    end
  endgenerate
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
  import phstep_pkg::*;
#(
  parameter int FINE_MAX       = 255,
  parameter int CMD_W          = 16,
  parameter bit HAS_DATA_SHIFT = 1'b1,
  localparam int FINE_W        = $clog2(FINE_MAX + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [CMD_W-1:0]         wrData,
  input  logic                     psDone,
  output logic                     psEn,
  output logic                     psInc,
  output logic                     busy,
  output logic                     overflow,
  output logic signed [FINE_W-1:0] fineOffset,
  output logic [1:0]               quarterIdx,
  output logic [1:0]               dataShift
);
  phStrobes_t strobes;

  phstep_ctrl #(.FINE_MAX(FINE_MAX), .FINE_W(FINE_W), .CMD_W(CMD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .psDone(psDone),
    .fineNow(fineOffset), .strobes(strobes), .psEn(psEn), .psInc(psInc),
    .busy(busy), .overflow(overflow)
  );

  phstep_dp #(.FINE_W(FINE_W), .QTR_W(2), .SHIFT_W(2),
              .HAS_DATA_SHIFT(HAS_DATA_SHIFT)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fineOffset(fineOffset),
    .quarterIdx(quarterIdx), .dataShift(dataShift)
  );
endmodule

// File: rtl/phase_step_ctrl_chk.sv
module phase_step_ctrl_chk #(
  parameter int FINE_MAX = 255,
  parameter int CMD_W    = 16,
  parameter int FINE_W   = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     wrEn,
  input logic [CMD_W-1:0]         wrData,
  input logic                     psDone,
  input logic                     psEn,
  input logic                     busy,
  input logic                     overflow,
  input logic signed [FINE_W-1:0] fineOffset,
  input logic [1:0]               quarterIdx,
  input logic [1:0]               dataShift
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    psEn && !psDone |=> !psEn);  // R2
  AST_FINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !psDone |=> $stable(fineOffset));  // R2
  AST_FINE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fineOffset) <= FINE_MAX) && (int'(fineOffset) >= -FINE_MAX));  // R3
  AST_QUARTER_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !busy && wrEn && wrData == CMD_W'(16'h0004) |=> quarterIdx == $past(quarterIdx) + 2'd1);  // R5
  AST_SHIFT_CEIL: assert property (@(posedge clk) disable iff (!rstN)
    !busy && wrEn && wrData == CMD_W'(16'h0010) && dataShift == 2'd3 |=> dataShift == 2'd3);  // R6
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrEn |=> overflow && $stable(quarterIdx));  // R7
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);  // R7
endmodule

bind phase_step_ctrl phase_step_ctrl_chk #(.FINE_MAX(FINE_MAX), .CMD_W(CMD_W), .FINE_W(FINE_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .psDone(psDone),
  .psEn(psEn), .busy(busy), .overflow(overflow), .fineOffset(fineOffset),
  .quarterIdx(quarterIdx), .dataShift(dataShift)
);

// File: tb/phase_step_ctrl_tb_top.sv
module phase_step_ctrl_tb_top;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, psDone = 1'b0;
  logic [15:0] wrData = '0;
  logic psEn, psInc, busy, overflow;
  logic signed [8:0] fineOffset;
  logic [1:0] quarterIdx, dataShift;

  int checks = 0, fails = 0;
  int expFine = 0, expQ = 0, expS = 0;
  bit expOvf = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  phase_step_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .psDone(psDone),
    .psEn(psEn), .psInc(psInc), .busy(busy), .overflow(overflow),
    .fineOffset(fineOffset), .quarterIdx(quarterIdx), .dataShift(dataShift)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    chk(int'(fineOffset) == expFine, {req, " fine"}, int'(fineOffset), expFine);
    chk(int'(quarterIdx) == expQ, {req, " quarter"}, int'(quarterIdx), expQ);
    chk(int'(dataShift) == expS, {req, " shift"}, int'(dataShift), expS);
    chk(overflow == expOvf, "R7 overflow", int'(overflow), int'(expOvf));
    chk(!busy && !psEn, {req, " idle"}, int'({busy, psEn}), 0);
  endtask

  task automatic sendCmd(input logic [15:0] c, input bit intrude);
    int n;
    bit dir;
    string req;
    n = 0; dir = 1'b0; req = "R8";
    case (c)
      16'h0001: begin req = (expFine < 255) ? "R2" : "R3"; if (expFine < 255) begin n = 1; dir = 1'b1; end end
      16'h0002: begin req = (expFine > -255) ? "R2" : "R3"; if (expFine > -255) begin n = 1; dir = 1'b0; end end
      16'h0003: begin req = "R4"; n = (expFine < 0) ? -expFine : expFine; dir = (expFine < 0); end
      16'h0004: begin req = "R5"; expQ = (expQ + 1) % 4; end
      16'h0008: begin req = "R5"; expQ = (expQ + 3) % 4; end
      16'h000C: begin req = "R5"; expQ = 0; end
      16'h0010: begin req = "R6"; if (expS < 3) expS++; end
      16'h0020: begin req = "R6"; if (expS > 0) expS--; end
      16'h0030: begin req = "R6"; expS = 0; end
      default: ;
    endcase
    @(negedge clk); wrEn = 1'b1; wrData = c;
    @(negedge clk); wrEn = 1'b0;
    for (int i = 0; i < n; i++) begin
      int d;
      chk(psEn && psInc == dir, {req, " pulse"}, int'({psEn, psInc}), int'({1'b1, dir}));
      d = intrude ? 2 : int'($urandom_range(1, 3));
      for (int j = 0; j < d; j++) begin
        @(negedge clk);
        if (j == 0) chk(!psEn, "R2 pulse width", int'(psEn), 0);
        chk(int'(fineOffset) == expFine, "R2 hold", int'(fineOffset), expFine);
        wrEn = intrude && i == 0 && j == 0;
        wrData = 16'h0004;
      end
      wrEn = 1'b0;
      psDone = 1'b1;
      @(negedge clk);
      psDone = 1'b0;
      expFine += dir ? 1 : -1;
    end
    if (intrude && n > 0) expOvf = 1'b1;
    checkState(req);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] codes [10];
    void'($urandom(32'd4711));
    codes = '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0008,
              16'h000C, 16'h0010, 16'h0020, 16'h0030, 16'h0101};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1");

    sendCmd(16'h0001, 1'b0); sendCmd(16'h0001, 1'b0); sendCmd(16'h0001, 1'b0);
    sendCmd(16'h0003, 1'b0);
    sendCmd(16'h0003, 1'b0);
    sendCmd(16'h0002, 1'b0); sendCmd(16'h0002, 1'b0);
    sendCmd(16'h0003, 1'b0);
    sendCmd(16'h0008, 1'b0);
    sendCmd(16'h0004, 1'b0);
    sendCmd(16'h0004, 1'b0); sendCmd(16'h0004, 1'b0);
    sendCmd(16'h000C, 1'b0);
    sendCmd(16'h0020, 1'b0);
    for (int k = 0; k < 4; k++) sendCmd(16'h0010, 1'b0);
    sendCmd(16'h0030, 1'b0);
    sendCmd(16'h0101, 1'b0);
    sendCmd(16'h0000, 1'b0);
    sendCmd(16'h8004, 1'b0);
    sendCmd(16'h0001, 1'b1);
    sendCmd(16'h0003, 1'b0);

    for (int k = 0; k < 256; k++) sendCmd(16'h0001, 1'b0);
    sendCmd(16'h0003, 1'b0);
    for (int k = 0; k < 256; k++) sendCmd(16'h0002, 1'b0);
    sendCmd(16'h0003, 1'b0);

    for (int k = 0; k < 400; k++) begin
      int idx;
      idx = int'($urandom_range(0, 9));
      if (idx == 9) sendCmd(16'($urandom_range(16'h0040, 16'hFFFF)), 1'b0);
      else sendCmd(codes[idx], ($urandom_range(0, 15) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule